// File: doc/BRIEF.md
# Protected Content Window Configuration Register

This block is a single 32-bit configuration register that controls a carve-out of protected content memory at the top of the graphics stolen region. Software programs a window base field, an enable, a memory-enable, an override flag, a mode flag and a method-enable flag through a simple word-wide register port with byte lane enables. The register applies its own write protection. A self-including sticky lock bit freezes everything until reset. A set enable bit freezes the base field and the override bit. An external platform lock input freezes every writable field while it is high.

The programmed base field also sets the window size: 1, 2, 4 or 8 MB. The window ends at the top of stolen memory, which is supplied as an input in 1 MB units. While memory-enable is set, a combinational hit output flags any access address that falls inside the window. The mode flag has no effect on this check.

Top module: `pcm_cfg_reg`

## Requirements
- R1: After synchronous reset every field reads 0, and `win_hit` is low for any address.
- R2: Bit 2 is a sticky lock. Once it is stored as 1, all later writes are dropped, including writes that try to clear bit 2. Only reset clears it.
- R3: While the stored enable bit (bit 1) is 1, writes to the base field (bits 31:20) are dropped, even with the sticky lock clear.
- R4: While the stored enable bit is 1, writes to the override bit (bit 4) are dropped.
- R5: Bits 19:7 and bit 5 are reserved. They always read 0, and writes to them are dropped. The register layout is base[31:20], method-enable[6], override[4], mode[3], lock[2], enable[1], memory-enable[0].
- R6: While `plat_lock` is high, every write is dropped. Writes take effect again once it is low.
- R7: Byte lane k (`cfg_be[k]`) updates only bits 8k+7:8k. Lanes that are not enabled keep their stored bits.
- R8: The window size in MB comes from the base field value: 0 or 1 gives 1, 2 gives 2, 3 or 4 gives 4, and 5 or more gives 8. The window covers [top − size, top) in MB units. Its lower bound is clamped to 0 when top is smaller than size.
- R9: `win_hit` is 1 exactly when memory-enable is 1 and `acc_addr[ADDR_W-1:20]` lies inside the window. It does not depend on the mode, override, lock or method-enable bits.
- R10: Locks are evaluated on the stored contents before a write. A single write that sets enable together with a new base and override stores all three.
- R11: A write strobe without `cfg_sel` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 1 | Register address match |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte lane enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Stored register contents, reserved bits 0 |
| plat_lock | input | 1 | External lock, freezes all writable fields while high |
| stolen_top_mb | input | ADDR_W-20 | Top of stolen memory in 1 MB units |
| acc_addr | input | ADDR_W | Access address to check |
| win_hit | output | 1 | Access falls in the enabled window |

## Verification
A write is captured on the rising edge that follows the falling edge where the bench applies it. Its effect on `cfg_rdata` is therefore due at the next falling edge, and the bench samples 1 ns after that edge. `win_hit` is combinational from `acc_addr`, `stolen_top_mb` and the stored fields. It is due within the same cycle the address is applied, so the bench sets the address at a falling edge and compares 1 ns later. The driver queues each expected value at the moment it applies the matching stimulus. The monitor pops that value at the same sampling point, so every comparison falls in the cycle its result is due.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int REG_W    = 32;
  localparam int LANES    = REG_W / 8;
  localparam int MB_SHIFT = 20;
  localparam int BASE_W   = REG_W - MB_SHIFT;

  // bit positions that the layout fixes
  localparam int POS_PME  = 0;
  localparam int POS_EN   = 1;
  localparam int POS_LOCK = 2;
  localparam int POS_MODE = 3;
  localparam int POS_OVR  = 4;
  localparam int POS_MEF  = 6;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic              mef;
    logic              ovr;
    logic              mode;
    logic              lock;
    logic              en;
    logic              pme;
  } pcm_fields_t;

  function automatic logic [REG_W-1:0] pcm_pack(pcm_fields_t f);
    logic [REG_W-1:0] w;
    w = '0;
    w[REG_W-1:MB_SHIFT] = f.base;
    w[POS_MEF]  = f.mef;
    w[POS_OVR]  = f.ovr;
    w[POS_MODE] = f.mode;
    w[POS_LOCK] = f.lock;
    w[POS_EN]   = f.en;
    w[POS_PME]  = f.pme;
    return w;
  endfunction
endpackage

// File: rtl/pcm_field_store.sv
module pcm_field_store
  import pcm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [LANES-1:0]    be,
  input  logic [REG_W-1:0]    wdata,
  input  logic                plat_lock,
  output pcm_fields_t         fields
);
  pcm_fields_t      f_q;
  logic [REG_W-1:0] cur_word;
  logic [REG_W-1:0] merged;
  logic             frz_all;
  logic             frz_en;

  assign cur_word = pcm_pack(f_q);

  // per-lane merge of write data over stored contents
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = (wr_en && be[g]) ? wdata[8*g +: 8] : cur_word[8*g +: 8];
  end

  logic unused_rsvd;
  assign unused_rsvd = ^{merged[MB_SHIFT-1:POS_MEF+1], merged[POS_OVR+1]};

  // lock sources, all taken from stored state before this write
  assign frz_all = f_q.lock | plat_lock;
  assign frz_en  = f_q.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q <= '0;
    end else if (!frz_all) begin
      f_q.pme  <= merged[POS_PME];
      f_q.en   <= merged[POS_EN];
      f_q.lock <= merged[POS_LOCK];
      f_q.mode <= merged[POS_MODE];
      f_q.mef  <= merged[POS_MEF];
      if (!frz_en) begin
        f_q.base <= merged[REG_W-1:MB_SHIFT];
        f_q.ovr  <= merged[POS_OVR];
      end
    end
  end

  assign fields = f_q;

  AST_LOCK_STAYS_SET: assert property (@(posedge clk) disable iff (rst)
    f_q.lock |=> f_q.lock); // R2
  AST_LOCK_FREEZES_ALL: assert property (@(posedge clk) disable iff (rst)
    f_q.lock |=> $stable(f_q)); // R2
  AST_BASE_HELD_BY_EN: assert property (@(posedge clk) disable iff (rst)
    f_q.en |=> $stable(f_q.base)); // R3
  AST_OVR_HELD_BY_EN: assert property (@(posedge clk) disable iff (rst)
    f_q.en |=> $stable(f_q.ovr)); // R4
  AST_PLAT_FREEZES_ALL: assert property (@(posedge clk) disable iff (rst)
    plat_lock |=> $stable(f_q)); // R6
endmodule

// File: rtl/pcm_window_chk.sv
module pcm_window_chk
  import pcm_pkg::*;
#(
  parameter int ADDR_W = 39
) (
  input  logic [BASE_W-1:0]          base_fld,
  input  logic                       pme,
  input  logic [ADDR_W-MB_SHIFT-1:0] top_mb,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       hit
);
  localparam int TOP_W = ADDR_W - MB_SHIFT;

  logic [3:0]       size_mb;
  logic [TOP_W-1:0] size_ext;
  logic [TOP_W-1:0] lo_mb;
  logic [TOP_W-1:0] addr_mb;
  logic unused_low;

  always_comb begin
    case (base_fld)
      BASE_W'(0), BASE_W'(1): size_mb = 4'd1;
      BASE_W'(2):             size_mb = 4'd2;
      BASE_W'(3), BASE_W'(4): size_mb = 4'd4;
      default:                size_mb = 4'd8;
    endcase
  end

  assign size_ext = {{(TOP_W-4){1'b0}}, size_mb};
  assign lo_mb    = (top_mb >= size_ext) ? (top_mb - size_ext) : '0;
  assign addr_mb  = addr[ADDR_W-1:MB_SHIFT];
  assign unused_low = ^addr[MB_SHIFT-1:0];
  assign hit      = pme && (addr_mb >= lo_mb) && (addr_mb < top_mb);
endmodule

// File: rtl/pcm_cfg_reg.sv
module pcm_cfg_reg
  import pcm_pkg::*;
#(
  parameter int ADDR_W = 39
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_sel,
  input  logic                       cfg_wr,
  input  logic [3:0]                 cfg_be,
  input  logic [31:0]                cfg_wdata,
  output logic [31:0]                cfg_rdata,
  input  logic                       plat_lock,
  input  logic [ADDR_W-MB_SHIFT-1:0] stolen_top_mb,
  input  logic [ADDR_W-1:0]          acc_addr,
  output logic                       win_hit
);
  pcm_fields_t fields;
  logic        wr_en;

  assign wr_en = cfg_sel & cfg_wr;

  pcm_field_store u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .be        (cfg_be),
    .wdata     (cfg_wdata),
    .plat_lock (plat_lock),
    .fields    (fields)
  );

  pcm_window_chk #(.ADDR_W(ADDR_W)) u_win (
    .base_fld (fields.base),
    .pme      (fields.pme),
    .top_mb   (stolen_top_mb),
    .addr     (acc_addr),
    .hit      (win_hit)
  );

  assign cfg_rdata = pcm_pack(fields);

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_rdata)); // R11
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[19:7] == '0) && !cfg_rdata[5]); // R5
  AST_HIT_NEEDS_PME: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> cfg_rdata[POS_PME]); // R9
  AST_HIT_BELOW_TOP: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> (acc_addr[ADDR_W-1:MB_SHIFT] < stolen_top_mb)); // R8
endmodule

// File: tb/tb_pcm_cfg_reg.sv
`timescale 1ns/1ps
module tb_pcm_cfg_reg;
  localparam int ADDR_W = 39;
  localparam int TOP_W  = ADDR_W - 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_sel = 1'b0;
  logic              cfg_wr = 1'b0;
  logic [3:0]        cfg_be = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              plat_lock = 1'b0;
  logic [TOP_W-1:0]  stolen_top_mb = TOP_W'(100);
  logic [ADDR_W-1:0] acc_addr = '0;
  logic              win_hit;

  always #5 clk = ~clk;

  pcm_cfg_reg #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .plat_lock(plat_lock),
    .stolen_top_mb(stolen_top_mb), .acc_addr(acc_addr), .win_hit(win_hit)
  );

  typedef struct {
    bit          is_hit;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // monitor: compare queued expectations 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_hit ? {31'b0, win_hit} : cfg_rdata;
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: %s actual=%h expected=%h", it.req,
                   it.is_hit ? "hit" : "rdata", act, it.exp);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d, input bit sel = 1'b1);
    @(negedge clk);
    cfg_sel = sel; cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_sel = 1'b0; cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic exp_rd(input logic [31:0] e, input string req);
    item_t it;
    it.is_hit = 1'b0; it.exp = e; it.req = req;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_hit(input logic [ADDR_W-1:0] a, input bit e, input string req);
    item_t it;
    acc_addr = a;
    it.is_hit = 1'b1; it.exp = {31'b0, e}; it.req = req;
    q.push_back(it);
    @(negedge clk);
  endtask

  function automatic logic [ADDR_W-1:0] mb(input int m);
    return ADDR_W'(m) << 20;
  endfunction

  initial begin
    do_reset();
    exp_rd(32'h0, "R1");
    exp_hit(mb(99), 1'b0, "R1");

    wr(4'b0001, 32'h0000_0001);
    exp_rd(32'h0000_0001, "R9");
    exp_hit(mb(99), 1'b1, "R8");
    exp_hit(mb(99) - 1, 1'b0, "R8");
    exp_hit(mb(100), 1'b0, "R9");

    wr(4'b1111, 32'hFFFF_FFE9);
    exp_rd(32'hFFF0_0049, "R5");
    exp_hit(mb(92), 1'b1, "R9");
    exp_hit(mb(92) - 1, 1'b0, "R8");

    wr(4'b1000, 32'h0200_0000);
    exp_rd(32'h02F0_0049, "R7");
    wr(4'b0100, 32'h0000_0000);
    exp_rd(32'h0200_0049, "R7");
    wr(4'b0011, 32'h0000_0000);
    exp_rd(32'h0200_0000, "R7");

    wr(4'b1111, 32'h0020_0001);
    exp_hit(mb(98), 1'b1, "R8");
    exp_hit(mb(97), 1'b0, "R8");
    wr(4'b1111, 32'h0030_0001);
    exp_hit(mb(96), 1'b1, "R8");
    exp_hit(mb(95), 1'b0, "R8");
    wr(4'b1111, 32'h0050_0001);
    exp_hit(mb(92), 1'b1, "R8");
    exp_hit(mb(91), 1'b0, "R8");
    stolen_top_mb = TOP_W'(3);
    exp_hit(mb(0), 1'b1, "R8");
    exp_hit(mb(3), 1'b0, "R8");
    stolen_top_mb = TOP_W'(100);

    wr(4'b1111, 32'hFFFF_FFFF, 1'b0);
    exp_rd(32'h0050_0001, "R11");

    plat_lock = 1'b1;
    wr(4'b1111, 32'h0000_0000);
    exp_rd(32'h0050_0001, "R6");
    plat_lock = 1'b0;

    wr(4'b1111, 32'h0070_0013);
    exp_rd(32'h0070_0013, "R10");

    wr(4'b1111, 32'h0010_0001);
    exp_rd(32'h0070_0011, "R3");
    exp_rd(32'h0070_0011, "R4");
    wr(4'b1111, 32'h0010_0003);
    exp_rd(32'h0010_0003, "R6");

    wr(4'b0001, 32'h0000_0007);
    exp_rd(32'h0010_0007, "R2");
    wr(4'b1111, 32'hFFFF_FFF0);
    exp_rd(32'h0010_0007, "R2");
    wr(4'b1111, 32'h0000_0000);
    exp_rd(32'h0010_0007, "R2");
    exp_hit(mb(99), 1'b1, "R2");

    do_reset();
    exp_rd(32'h0, "R1");
    exp_hit(mb(99), 1'b0, "R1");

    @(negedge clk);
    #3;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: all actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule